// File: doc/BRIEF.md
# Oversampled UART Receive Engine

This block is the serial receive path of a UART. It takes an asynchronous receive line and an oversampling clock enable (`os_tick`), which the baud-rate generator supplies. The line passes through a two-flop synchronizer. While the receiver is idle, a low level seen on an `os_tick` starts a counter that runs at the oversampling rate. The receiver checks the start bit half a bit period later. If the line is high again at that point, the start is treated as false and dropped. Each later bit is sampled one full bit period after the previous sample point.

Run-time controls select the oversampling ratio (16x, 8x or 4x), the word length (5 to 8 bits), parity (on or off, odd or even) and one or two stop bits. For each finished character the block raises a single-cycle strobe. The strobe carries the data byte and three error tags: parity, framing and break. It also exposes a busy flag and a pulse at every bit sample point, which timeout logic outside the block can count.

Top module: `uart_rx_engine`

## Requirements
- R1: When synchronous reset is released, `char_valid`, `bit_tick`, `busy` and all three error tags are low.
- R2: `os_sel` encodes the ratio: 00 is 16x, 01 is 8x, 10 is 4x, and 11 is treated as 16x. With `os_tick` high every cycle, the first `bit_tick` appears 3 + ratio/2 clock cycles after the line is driven low. These cycles are the two synchronizer stages, the detection cycle and half a bit of ticks.
- R3: If the line is high again at the start-bit centre, the start is false. The receiver returns to idle with `busy` low, and no character is produced.
- R4: Data arrives LSB first. `wlen_sel` 00/01/10/11 selects 5/6/7/8 data bits. In a shorter word, the unused upper bits of `char_data` are zero.
- R5: When `par_en` is high, a parity bit follows the data. `par_odd`=1 selects odd parity and 0 selects even. `err_parity` is set when the received parity bit does not match.
- R6: `err_frame` is set when the first stop bit samples low.
- R7: `err_break` is set when every data bit, the parity bit if present, and the first stop bit all sample low. A break always also sets `err_frame`.
- R8: After a framing error, the receiver keeps `busy` high and ignores the line until the line returns high. Only then can it accept a new start bit.
- R9: With `stop2` high and a valid first stop bit, the receiver stays busy for a second stop period that is timed but not checked. After a framing error, no second stop period is timed.
- R10: `bit_tick` pulses once at each sample point. A frame gives 1 + data bits + parity bit + timed stop bits pulses.
- R11: All bit timing advances only on cycles where `os_tick` is high. With `os_tick` held low, a low line does not make the block busy.
- R12: `char_valid` is a single-cycle pulse per character. The data and tags are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling clock enable |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| os_sel | input | 2 | Oversampling ratio select |
| wlen_sel | input | 2 | Word length select (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| stop2 | input | 1 | Two stop bits |
| char_valid | output | 1 | Character strobe |
| char_data | output | 8 | Received character |
| err_parity | output | 1 | Parity error tag |
| err_frame | output | 1 | Framing error tag |
| err_break | output | 1 | Break tag |
| busy | output | 1 | Receiver is inside a frame or waiting for the line to go high |
| bit_tick | output | 1 | Pulse at each bit sample point |

## Verification
The character strobe and the error tags land in the same cycle, and a break must raise its tag together with the framing tag. The bench provokes this with all-low frames, with and without a parity bit that rescues the line from being a break. It then reads all three tags in the strobe cycle against values computed from the frame that was sent. A second overlap is the framing error, which ends the frame and enters the wait for a high line within one sample. The bench holds the line low afterwards and checks that no extra sample point or character follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_WAIT_HIGH
  } rx_state_t;

  // Oversampling ticks per bit for a ratio select code
  function automatic int os_ratio(input logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer
  import uart_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       os_tick,
  input  logic       run,
  input  logic [1:0] os_sel,
  output logic       hit
);

  logic [CNT_W-1:0] cnt;
  logic             first_half;
  logic [CNT_W:0]   ratio;
  logic [CNT_W:0]   target;

  assign ratio  = (CNT_W+1)'(os_ratio(os_sel));
  assign target = first_half ? ((ratio >> 1) - 1'b1) : (ratio - 1'b1);
  assign hit    = run && os_tick && ({1'b0, cnt} == target);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt        <= '0;
      first_half <= 1'b1;
    end else if (os_tick) begin
      if (hit) begin
        cnt        <= '0;
        first_half <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < ratio); // R2

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx,
  input  logic              hit,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  output logic              timer_run,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              busy,
  output logic              bit_tick
);

  rx_state_t         state;
  logic [DATA_W-1:0] sr;
  logic [IDX_W-1:0]  idx;
  logic              all_low;
  logic              par_bit;
  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] aligned;
  logic              par_exp;

  assign nbits     = LEN_W'(wlen_sel) + LEN_W'(DATA_W - 3);
  assign aligned   = sr >> (LEN_W'(DATA_W) - nbits);
  assign par_exp   = (^aligned) ^ par_odd;
  assign timer_run = (state != ST_IDLE) && (state != ST_WAIT_HIGH);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sr         <= '0;
      idx        <= '0;
      all_low    <= 1'b1;
      par_bit    <= 1'b0;
      char_valid <= 1'b0;
      char_data  <= '0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      err_break  <= 1'b0;
      bit_tick   <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      bit_tick   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (os_tick && !rx) state <= ST_START;
        end
        ST_START: begin
          if (hit) begin
            bit_tick <= 1'b1;
            if (rx) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_DATA;
              idx     <= '0;
              sr      <= '0;
              all_low <= 1'b1;
              par_bit <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (hit) begin
            bit_tick <= 1'b1;
            sr       <= {rx, sr[DATA_W-1:1]};
            all_low  <= all_low & ~rx;
            idx      <= idx + 1'b1;
            if (LEN_W'(idx) == nbits - 1'b1)
              state <= par_en ? ST_PAR : ST_STOP1;
          end
        end
        ST_PAR: begin
          if (hit) begin
            bit_tick <= 1'b1;
            par_bit  <= rx;
            all_low  <= all_low & ~rx;
            state    <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (hit) begin
            bit_tick   <= 1'b1;
            char_valid <= 1'b1;
            char_data  <= aligned;
            err_parity <= par_en && (par_bit != par_exp);
            err_frame  <= ~rx;
            err_break  <= ~rx & all_low;
            if (!rx)       state <= ST_WAIT_HIGH;
            else if (stop2) state <= ST_STOP2;
            else           state <= ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (hit) begin
            bit_tick <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_WAIT_HIGH: begin
          if (rx) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    (char_valid && err_break) |-> err_frame); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid); // R12
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_HIGH && !rx) |=> (state == ST_WAIT_HIGH)); // R8
  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && hit && rx) |=> (state == ST_IDLE && !char_valid)); // R3

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic [1:0]        os_sel,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              busy,
  output logic              bit_tick
);

  logic rx_s;
  logic hit;
  logic timer_run;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rx_in),
    .q_sync  (rx_s)
  );

  uart_rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .os_tick (os_tick),
    .run     (timer_run),
    .os_sel  (os_sel),
    .hit     (hit)
  );

  uart_rx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .os_tick    (os_tick),
    .rx         (rx_s),
    .hit        (hit),
    .wlen_sel   (wlen_sel),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .stop2      (stop2),
    .timer_run  (timer_run),
    .char_valid (char_valid),
    .char_data  (char_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_break  (err_break),
    .busy       (busy),
    .bit_tick   (bit_tick)
  );

  AST_TICK_NEEDS_OS: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> $past(os_tick)); // R11

endmodule

// File: tb/uart_rx_engine_bench.sv
module uart_rx_engine_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] os_sel = 2'b00;
  logic [1:0] wlen_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       stop2 = 1'b0;
  logic       char_valid;
  logic [7:0] char_data;
  logic       err_parity, err_frame, err_break, busy, bit_tick;

  int n_checks = 0;
  int n_fail = 0;
  int tick_div = 1;
  int dcnt = 0;
  bit tick_on = 1'b1;

  always #5 clk = ~clk;

  uart_rx_engine u_uart_rx_engine (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .os_sel(os_sel), .wlen_sel(wlen_sel), .par_en(par_en), .par_odd(par_odd),
    .stop2(stop2), .char_valid(char_valid), .char_data(char_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .busy(busy), .bit_tick(bit_tick)
  );

  // oversampling enable, driven away from the active edge
  always @(negedge clk) begin
    os_tick = tick_on && (dcnt == 0);
    dcnt = (dcnt + 1 >= tick_div) ? 0 : dcnt + 1;
  end

  // monitor: monotonic counters, read as differences
  int mon_chars = 0, mon_ticks = 0, mon_double = 0;
  logic [7:0] cap_data;
  logic cap_pe, cap_fe, cap_bk, prev_cv = 1'b0;
  always @(negedge clk) begin
    if (char_valid) begin
      mon_chars++;
      cap_data = char_data; cap_pe = err_parity; cap_fe = err_frame; cap_bk = err_break;
      if (prev_cv) mon_double++;
    end
    if (bit_tick) mon_ticks++;
    prev_cv = char_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 4 : 16;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] os, input logic [1:0] wl, input logic pen,
                      input logic podd, input logic st2, input logic [7:0] d,
                      input logic badp, input logic stlow);
    int n;
    int nb;
    logic [7:0] m;
    os_sel = os; wlen_sel = wl; par_en = pen; par_odd = podd; stop2 = st2;
    n = ratio_of(os) * tick_div;
    nb = int'(wl) + 5;
    m = d & 8'((1 << nb) - 1);
    hold(2);
    rx_in = 1'b0; hold(n);
    for (int i = 0; i < nb; i++) begin rx_in = m[i]; hold(n); end
    if (pen) begin rx_in = (^m) ^ podd ^ badp; hold(n); end
    rx_in = ~stlow; hold(n);
    if (st2) begin rx_in = 1'b1; hold(n); end
    rx_in = 1'b1; hold(3 * n);
  endtask

  // {os, wl, pen, podd, st2, data, badp, stlow, exp_pe, exp_fe, exp_bk}
  localparam logic [19:0] VECS [9] = '{
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic run_vec(input logic [19:0] v, input string tag);
    int c0, t0, nb, exp_ticks;
    logic [7:0] m;
    c0 = mon_chars; t0 = mon_ticks;
    send(v[19:18], v[17:16], v[15], v[14], v[13], v[12:5], v[4], v[3]);
    nb = int'(v[17:16]) + 5;
    m = v[12:5] & 8'((1 << nb) - 1);
    exp_ticks = 1 + nb + int'(v[15]) + ((v[13] && !v[3]) ? 2 : 1);
    chk({tag, " R12 one char"}, mon_chars - c0, 1);
    chk({tag, " R4 data"}, int'(cap_data), int'(m));
    chk({tag, " R5 parity tag"}, int'(cap_pe), int'(v[2]));
    chk({tag, " R6 frame tag"}, int'(cap_fe), int'(v[1]));
    chk({tag, " R7 break tag"}, int'(cap_bk), int'(v[0]));
    chk({tag, " R10 R9 bit ticks"}, mon_ticks - t0, exp_ticks);
    chk({tag, " R8 idle after"}, int'(busy), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int c0, t0, n;
    hold(4);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(char_valid), 0);
    chk("R1 tick after reset", int'(bit_tick), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 tags after reset", int'({err_parity, err_frame, err_break}), 0);

    for (int i = 0; i < 9; i++) run_vec(VECS[i], $sformatf("vec%0d", i));
    chk("R12 no double strobe", mon_double, 0);

    // R2 latency to the start-bit sample point for each ratio
    for (int s = 0; s < 3; s++) begin
      os_sel = 2'(s);
      hold(4);
      rx_in = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!bit_tick && n < 64);
      chk($sformatf("R2 start sample latency os%0d", s), n, 3 + ratio_of(2'(s)) / 2);
      rx_in = 1'b1;
      hold(16 * 14);
    end

    // R3 false start: low for fewer clocks than half a bit
    os_sel = 2'b00;
    c0 = mon_chars;
    hold(4); rx_in = 1'b0; hold(4); rx_in = 1'b1; hold(40);
    chk("R3 false start no char", mon_chars - c0, 0);
    chk("R3 false start idle", int'(busy), 0);

    // R8 break then line held low: waits for high
    os_sel = 2'b00; wlen_sel = 2'b11; par_en = 1'b0; stop2 = 1'b0;
    c0 = mon_chars; t0 = mon_ticks;
    hold(2); rx_in = 1'b0; hold(16 * 10 + 100);
    chk("R8 busy while low", int'(busy), 1);
    chk("R8 one char only", mon_chars - c0, 1);
    chk("R7 break tag held low", int'(cap_bk), 1);
    chk("R8 no extra ticks", mon_ticks - t0, 10);
    rx_in = 1'b1; hold(40);
    chk("R8 idle after high", int'(busy), 0);
    run_vec(VECS[0], "R8 recover");

    // R11 gated tick: one tick every third clock
    tick_div = 3;
    run_vec(VECS[1], "R11 gated");
    tick_div = 1;

    // R11 no ticks: low line leaves block idle
    tick_on = 1'b0;
    hold(4); rx_in = 1'b0; hold(100);
    chk("R11 no ticks idle", int'(busy), 0);
    rx_in = 1'b1; hold(4);
    tick_on = 1'b1;
    hold(8);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule